// File: doc/BRIEF.md
# Page Write Buffer and Write Cycle Controller

This block sits between a serial slave protocol engine and a byte-wide memory array. During a write transaction it takes each received data byte and places it in a small page latch. The slot is chosen by a 4-bit offset that starts at the low bits of the captured byte address. The upper address bits pick one page, and that page stays fixed for the whole transaction. The block also watches the write-control input over the window that runs from the start condition to the end of the address byte. When protection is seen in that window, every data byte is refused.

The engine reports the closing stop and flags whether it fell in the slot right after an acknowledge. Only such a stop, with at least one byte latched, commits the transaction. The block then raises `busy_o` for a fixed number of system clock cycles. Early in that window it copies each received slot to the array, one strobe per cycle, in ascending offset order. While busy, it ignores every input from the engine. The engine uses `busy_o` to refuse select bytes, so a bus master can poll for completion with acknowledges.

Top module: `page_write_ctrl`

## Requirements
- R1: After reset, `busy_o`, `mem_we_o` and `data_ack_o` are all 0.
- R2: When write protection is not seen, each data byte that follows an accepted address byte gets a one-cycle `data_ack_o` pulse in the cycle after its strobe.
- R3: If `wc_i` is 1 in any cycle from the start condition through the address-byte strobe, the data bytes of that transaction get no acknowledge, nothing is written and no write cycle starts.
- R4: `wc_i` changes after the address byte have no effect on acknowledges or on the bytes written.
- R5: A stop with `stop_slot_i`=1 and at least one byte latched raises `busy_o` in the next cycle. `busy_o` then stays 1 for exactly WR_CYCLES cycles.
- R6: A stop with `stop_slot_i`=0 discards the latched bytes. No write cycle starts, and a later committing stop with no new bytes starts none either.
- R7: During the write cycle, the block issues one `mem_we_o` strobe per received offset, in ascending offset order. `mem_addr_o` is {page bits, 4-bit offset} and `mem_wdata_o` is the byte held for that offset. Offsets that were not received are not written.
- R8: After each data byte, only the 4 low address bits advance, wrapping from 15 to 0 inside the same page. A later byte that lands on an offset already filled replaces the earlier one.
- R9: While `busy_o` is 1, starts, address bytes, data bytes and stops are ignored. No acknowledge is given, and nothing received then is written later.
- R10: A start condition clears the latch. Bytes from a transaction that ends in a repeated start are never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse: start condition seen |
| addr_load_i | input | 1 | One-cycle pulse: address byte complete, `addr_i` valid |
| addr_i | input | ADDR_W | Full byte address captured by the engine |
| data_strobe_i | input | 1 | One-cycle pulse: data byte complete, `data_i` valid |
| data_i | input | 8 | Received data byte |
| stop_i | input | 1 | One-cycle pulse: stop condition seen |
| stop_slot_i | input | 1 | With `stop_i`: the stop fell right after an acknowledge |
| wc_i | input | 1 | Write control, 1 = protected (tie low when unused) |
| data_ack_o | output | 1 | One-cycle pulse: acknowledge the last data byte |
| busy_o | output | 1 | Internal write cycle in progress |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | 8 | Array write data |

## Verification
The embedded assertions check on every cycle that:
- array strobes appear only while busy;
- busy rises only after a stop in the acknowledge slot;
- no acknowledge is given while busy;
- strobes stay inside one page, in rising offset order;
- the protection flag is frozen once the address byte is taken.

Some behaviour depends on values and counts across a whole transaction, so only the bench's scenarios can show it:
- the exact data written to each address;
- overwrite on page wrap;
- discard after an unslotted stop or a repeated start;
- the exact length of the busy window.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  localparam int BYTE_W = 8;
  typedef enum logic {CYC_IDLE, CYC_RUN} cyc_state_t;
endpackage

// File: rtl/pwc_wp_window.sv
module pwc_wp_window (
  input  logic clk,
  input  logic rst,
  input  logic accept_i,
  input  logic start_i,
  input  logic addr_load_i,
  input  logic stop_i,
  input  logic wc_i,
  output logic open_o,
  output logic armed_o,
  output logic prot_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      open_o  <= 1'b0;
      armed_o <= 1'b0;
      prot_o  <= 1'b0;
    end else if (accept_i) begin
      if (start_i) begin
        open_o  <= 1'b1;
        armed_o <= 1'b0;
        prot_o  <= wc_i;
      end else if (stop_i) begin
        open_o  <= 1'b0;
        armed_o <= 1'b0;
      end else if (open_o) begin
        prot_o <= prot_o | wc_i;
        if (addr_load_i) begin
          open_o  <= 1'b0;
          armed_o <= 1'b1;
        end
      end
    end
  end

  AST_PROT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    armed_o && $past(armed_o) |-> $stable(prot_o)); // R4
endmodule

// File: rtl/pwc_page_latch.sv
module pwc_page_latch #(
  parameter int PAGE_BYTES = 16,
  parameter int IDX_W      = $clog2(PAGE_BYTES)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr_all_i,
  input  logic                      wr_en_i,
  input  logic [IDX_W-1:0]          wr_idx_i,
  input  logic [pwc_pkg::BYTE_W-1:0] wr_data_i,
  input  logic                      rd_en_i,
  input  logic [IDX_W-1:0]          rd_idx_i,
  output logic                      rd_hit_o,
  output logic [pwc_pkg::BYTE_W-1:0] rd_data_o,
  output logic                      any_valid_o
);
  logic [pwc_pkg::BYTE_W-1:0] store [PAGE_BYTES];
  logic [PAGE_BYTES-1:0]      filled;

  // storage: one write port, one registered read port, no reset
  always_ff @(posedge clk) begin
    if (wr_en_i) store[wr_idx_i] <= wr_data_i;
    rd_data_o <= store[rd_idx_i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      filled   <= '0;
      rd_hit_o <= 1'b0;
    end else begin
      rd_hit_o <= rd_en_i & filled[rd_idx_i];
      if (clr_all_i) begin
        filled <= '0;
      end else begin
        if (wr_en_i) filled[wr_idx_i] <= 1'b1;
        if (rd_en_i) filled[rd_idx_i] <= 1'b0;
      end
    end
  end

  assign any_valid_o = |filled;

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    $past(clr_all_i) |-> !any_valid_o); // R10
endmodule

// File: rtl/pwc_cycle.sv
module pwc_cycle #(
  parameter int WR_CYCLES  = 250000,
  parameter int PAGE_BYTES = 16,
  parameter int IDX_W      = $clog2(PAGE_BYTES),
  parameter int CNT_W      = $clog2(WR_CYCLES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_i,
  output logic             rd_en_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             busy_o
);
  import pwc_pkg::*;
  cyc_state_t       state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= CYC_IDLE;
      cnt   <= '0;
    end else if (state == CYC_IDLE) begin
      cnt <= '0;
      if (go_i) state <= CYC_RUN;
    end else begin
      if (cnt == CNT_W'(WR_CYCLES - 1)) begin
        state <= CYC_IDLE;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign busy_o   = (state == CYC_RUN);
  assign rd_en_o  = busy_o && (cnt < CNT_W'(PAGE_BYTES));
  assign rd_idx_o = cnt[IDX_W-1:0];

  AST_GO_STARTS: assert property (@(posedge clk) disable iff (rst)
    go_i && !busy_o |=> busy_o); // R5
endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl #(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 250000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_strobe_i,
  input  logic [7:0]        data_i,
  input  logic              stop_i,
  input  logic              stop_slot_i,
  input  logic              wc_i,
  output logic              data_ack_o,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o
);
  localparam int IDX_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - IDX_W;
  localparam int CNT_W  = $clog2(WR_CYCLES);

  if (WR_CYCLES <= PAGE_BYTES) begin : g_bad_cfg
    $error("WR_CYCLES must exceed PAGE_BYTES");
  end

  logic              accept, win_open, armed, prot;
  logic              take_addr, take_data, commit, clr_all;
  logic [PAGE_W-1:0] page_q;
  logic [IDX_W-1:0]  ofs_q, slot_q;
  logic              rd_en, any_valid;
  logic [IDX_W-1:0]  rd_idx;

  assign accept    = !busy_o;
  assign take_addr = accept && !start_i && !stop_i && win_open && addr_load_i;
  assign take_data = accept && !start_i && !stop_i && armed && data_strobe_i;
  assign commit    = accept && !start_i && stop_i && stop_slot_i && any_valid;
  assign clr_all   = accept && (start_i || (stop_i && !commit));

  pwc_wp_window u_window (
    .clk(clk), .rst(rst), .accept_i(accept), .start_i(start_i),
    .addr_load_i(addr_load_i), .stop_i(stop_i), .wc_i(wc_i),
    .open_o(win_open), .armed_o(armed), .prot_o(prot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q     <= '0;
      ofs_q      <= '0;
      data_ack_o <= 1'b0;
    end else begin
      data_ack_o <= take_data && !prot;
      if (take_addr) begin
        page_q <= addr_i[ADDR_W-1:IDX_W];
        ofs_q  <= addr_i[IDX_W-1:0];
      end else if (take_data) begin
        ofs_q <= ofs_q + 1'b1;  // wraps inside the page
      end
    end
  end

  pwc_page_latch #(.PAGE_BYTES(PAGE_BYTES), .IDX_W(IDX_W)) u_latch (
    .clk(clk), .rst(rst), .clr_all_i(clr_all),
    .wr_en_i(take_data && !prot), .wr_idx_i(ofs_q), .wr_data_i(data_i),
    .rd_en_i(rd_en), .rd_idx_i(rd_idx),
    .rd_hit_o(mem_we_o), .rd_data_o(mem_wdata_o), .any_valid_o(any_valid)
  );

  pwc_cycle #(.WR_CYCLES(WR_CYCLES), .PAGE_BYTES(PAGE_BYTES),
              .IDX_W(IDX_W), .CNT_W(CNT_W)) u_cycle (
    .clk(clk), .rst(rst), .go_i(commit),
    .rd_en_o(rd_en), .rd_idx_o(rd_idx), .busy_o(busy_o)
  );

  always_ff @(posedge clk) begin
    if (rst)        slot_q <= '0;
    else if (rd_en) slot_q <= rd_idx;
  end

  assign mem_addr_o = {page_q, slot_q};

  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> busy_o); // R7
  AST_COMMIT_ON_SLOT: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(stop_i && stop_slot_i)); // R5
  AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> !data_ack_o); // R9
  AST_WE_SAME_PAGE: assert property (@(posedge clk) disable iff (rst)
    mem_we_o && $past(mem_we_o) |->
      mem_addr_o[ADDR_W-1:IDX_W] == $past(mem_addr_o[ADDR_W-1:IDX_W])); // R8
  AST_WE_ASCENDING: assert property (@(posedge clk) disable iff (rst)
    mem_we_o && $past(mem_we_o) |->
      mem_addr_o[IDX_W-1:0] > $past(mem_addr_o[IDX_W-1:0])); // R7
endmodule

// File: tb/page_write_ctrl_test.sv
module page_write_ctrl_test;
  localparam int AW = 11;
  localparam int WC = 40;

  logic clk = 0, rst = 1;
  logic start_i = 0, addr_load_i = 0, data_strobe_i = 0, stop_i = 0;
  logic stop_slot_i = 0, wc_i = 0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0] data_i = '0;
  logic data_ack_o, busy_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [7:0] mem_wdata_o;

  int errors = 0, checks = 0, nrec = 0;
  bit done = 0;
  logic [AW-1:0] rec_a [32];
  logic [7:0]    rec_d [32];

  always #10 clk = ~clk;

  page_write_ctrl #(.ADDR_W(AW), .PAGE_BYTES(16), .WR_CYCLES(WC)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .addr_load_i(addr_load_i),
    .addr_i(addr_i), .data_strobe_i(data_strobe_i), .data_i(data_i),
    .stop_i(stop_i), .stop_slot_i(stop_slot_i), .wc_i(wc_i),
    .data_ack_o(data_ack_o), .busy_o(busy_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o));

  always @(negedge clk) if (mem_we_o && nrec < 32) begin
    rec_a[nrec] = mem_addr_o; rec_d[nrec] = mem_wdata_o; nrec++;
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_start(bit wc);
    @(negedge clk) start_i = 1; wc_i = wc;
    @(negedge clk) start_i = 0;
  endtask
  task automatic do_addr(logic [AW-1:0] a, bit wc);
    @(negedge clk) addr_load_i = 1; addr_i = a; wc_i = wc;
    @(negedge clk) addr_load_i = 0;
  endtask
  task automatic do_byte(logic [7:0] d, output bit ack);
    @(negedge clk) data_strobe_i = 1; data_i = d;
    @(negedge clk) data_strobe_i = 0; ack = data_ack_o;
  endtask
  task automatic do_stop(bit slot, bit wait_busy, output int blen);
    @(negedge clk) stop_i = 1; stop_slot_i = slot;
    @(negedge clk) stop_i = 0; stop_slot_i = 0;
    blen = 0;
    if (wait_busy) while (busy_o) begin blen++; @(negedge clk); end
  endtask

  // {wc, address, byte count, stop in ack slot}
  localparam logic [17:0] VEC [7] = '{
    {1'b0, 11'h123, 5'd1,  1'b1},
    {1'b0, 11'h7F0, 5'd16, 1'b1},
    {1'b0, 11'h05C, 5'd6,  1'b1},
    {1'b0, 11'h200, 5'd20, 1'b1},
    {1'b1, 11'h300, 5'd3,  1'b1},
    {1'b0, 11'h400, 5'd4,  1'b0},
    {1'b0, 11'h000, 5'd0,  1'b1}
  };

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy after reset", busy_o, 0);
    chk("R1 we after reset", mem_we_o, 0);
    chk("R1 ack after reset", data_ack_o, 0);
    rst = 0;

    for (int i = 0; i < 7; i++) begin
      bit vwc, vslot, ack; int n, acks, blen, k, o, expw;
      logic [AW-1:0] va; logic [7:0] d;
      bit ev [16]; logic [7:0] ed [16];
      vwc = VEC[i][17]; va = VEC[i][16:6]; n = int'(VEC[i][5:1]); vslot = VEC[i][0];
      for (int j = 0; j < 16; j++) begin ev[j] = 0; ed[j] = 0; end
      nrec = 0; acks = 0; o = int'(va[3:0]);
      do_start(vwc); do_addr(va, vwc);
      for (int j = 0; j < n; j++) begin
        d = 8'(16 * i + 1 + j);
        do_byte(d, ack);
        if (ack) acks++;
        if (!vwc) begin ev[o] = 1; ed[o] = d; end
        o = (o + 1) & 15;
      end
      do_stop(vslot, 1, blen);
      wc_i = 0;
      chk($sformatf("R2/R3 vec%0d acks", i), acks, vwc ? 0 : n);
      chk($sformatf("R5/R6 vec%0d busy len", i), blen, (!vwc && vslot && n > 0) ? WC : 0);
      k = 0;
      if (!vwc && vslot)
        for (int s = 0; s < 16; s++) if (ev[s]) begin
          if (k < nrec) begin
            chk($sformatf("R7/R8 vec%0d addr%0d", i, k), int'(rec_a[k]), int'({va[10:4], 4'(s)}));
            chk($sformatf("R7/R8 vec%0d data%0d", i, k), int'(rec_d[k]), int'(ed[s]));
          end
          k++;
        end
      expw = k;
      chk($sformatf("R7 vec%0d write count", i), nrec, expw);
    end

    // R4: wc rises after the address byte
    begin
      bit a0, a1; int blen;
      nrec = 0;
      do_start(0); do_addr(11'h0A4, 0);
      wc_i = 1;
      do_byte(8'h5A, a0); do_byte(8'hA5, a1);
      do_stop(1, 1, blen); wc_i = 0;
      chk("R4 acks", int'(a0) + int'(a1), 2);
      chk("R4 writes", nrec, 2);
      if (nrec == 2) chk("R4 data", int'(rec_d[1]), 8'hA5);
    end

    // R3: short wc pulse between start and address
    begin
      bit a0; int blen;
      nrec = 0;
      do_start(0);
      @(negedge clk) wc_i = 1;
      @(negedge clk) wc_i = 0;
      do_addr(11'h0B0, 0);
      do_byte(8'h11, a0);
      do_stop(1, 1, blen);
      chk("R3 pulse no ack", a0, 0);
      chk("R3 pulse no busy", blen, 0);
      chk("R3 pulse no write", nrec, 0);
    end

    // R9: traffic while busy is ignored
    begin
      bit a0, a1; int blen;
      nrec = 0;
      do_start(0); do_addr(11'h0C2, 0); do_byte(8'h77, a0);
      do_stop(1, 0, blen);
      chk("R5 busy next cycle", busy_o, 1);
      do_start(0); do_addr(11'h0D0, 0); do_byte(8'h99, a1);
      chk("R9 no ack while busy", a1, 0);
      do_stop(1, 0, blen);
      while (busy_o) @(negedge clk);
      chk("R9 one write", nrec, 1);
      do_stop(1, 1, blen);
      chk("R9 nothing held", blen, 0);
      chk("R9 no extra write", nrec, 1);
    end

    // R10: repeated start drops the first group
    begin
      bit a; int blen;
      nrec = 0;
      do_start(0); do_addr(11'h150, 0); do_byte(8'hAA, a); do_byte(8'hBB, a);
      do_start(0); do_addr(11'h163, 0); do_byte(8'hCC, a);
      do_stop(1, 1, blen);
      chk("R10 write count", nrec, 1);
      if (nrec == 1) begin
        chk("R10 addr", int'(rec_a[0]), 11'h163);
        chk("R10 data", int'(rec_d[0]), 8'hCC);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule